// File: doc/BRIEF.md
# Computation Cycle Sequencer with Interrupt

This controller sets the pace of a metering engine's result updates. Filtered conversion strobes arrive once per output word. The sequencer counts them, and after every N strobes it emits a one-cycle update pulse. That pulse tells the arithmetic datapath to latch its accumulated energy and RMS values. N comes from a programmable cycle-count input, and a value of zero is treated as one.

Nothing is counted until a start command arrives. A mode bit is sampled with that command. When the bit is clear, the sequencer runs exactly one computation cycle and then goes idle. When the bit is set, it runs cycles back to back until the next start command. Each completed cycle sets a sticky data-ready status bit. Software clears that bit by writing a one to it. An interrupt output is active while data-ready is set and the interrupt enable is high.

RMS results need one full cycle of history before they can be trusted. For that reason an RMS-valid flag is held low through the first completed cycle after every start. Energy results are valid from the first cycle.

Top module: `comp_cycle_sequencer`

## Requirements
- R1: After reset, updatePulse, dataReady, rmsValid and irq are 0. Strobes received before any start command cause no update pulse.
- R2: updatePulse is high for one cycle, in the clock cycle that follows the edge where the Nth counted strobe since start (or since the previous update) is sampled. A strobe sampled in the same cycle as startCmd is not counted.
- R3: dataReady is set together with updatePulse and at no other time. It stays set until clearDataReady is sampled high in a cycle without a new update.
- R4: irq equals dataReady AND irqEnable, where irqEnable = 1 means the interrupt is not masked. irq drops in the cycle after a clear write.
- R5: With startContinuous = 0 at start, exactly one update pulse occurs. Further strobes are then ignored until the next start.
- R6: With startContinuous = 1 at start, update pulses repeat every N strobes with no gap.
- R7: rmsValid is 0 after every start. It becomes 1 with the second update pulse after that start, so it never rises in single-cycle mode.
- R8: With cycleCount = 1, every strobe produces an update pulse.
- R9: cycleCount = 0 behaves exactly like cycleCount = 1.
- R10: A start command during a running cycle discards the partial count, so N further strobes are needed. It also clears rmsValid.
- R11: When a clear write and an update happen in the same cycle, dataReady ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convStrobe | input | 1 | One-cycle pulse per filtered conversion |
| startCmd | input | 1 | Start (or restart) command pulse |
| startContinuous | input | 1 | Mode sampled with startCmd: 1 = continuous, 0 = single cycle |
| cycleCount | input | CNT_W | Conversions per computation cycle (0 means 1) |
| irqEnable | input | 1 | 1 = data-ready interrupt unmasked |
| clearDataReady | input | 1 | Write-one-to-clear pulse for data-ready |
| updatePulse | output | 1 | Latch strobe for energy and RMS results |
| dataReady | output | 1 | Sticky status: a computation cycle finished |
| rmsValid | output | 1 | Latched RMS results are valid |
| irq | output | 1 | Interrupt, active high |

## Verification
The hardest situation to reach from the ports is a clear write that lands in the very cycle a computation cycle completes. Hitting it requires the clear pulse to coincide with the Nth strobe. The stimulus counts strobes for a small N and issues the clear together with the final strobe. A second timing corner is a restart that arrives one strobe short of completion. The bench reaches it by issuing N-1 strobes, restarting, and checking that no pulse appears until N more strobes have arrived. A behavioural model runs alongside and is compared on every clock, so these corners are also checked cycle by cycle.

// File: rtl/comp_seq_pkg.sv
package comp_seq_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seqState_t;

  typedef struct packed {
    logic clearCnt;
    logic advance;
  } seqCtl_t;
endpackage

// File: rtl/comp_seq_datapath.sv
module comp_seq_datapath
  import comp_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [CNT_W-1:0] cycleCount,
  output logic             lastStrobe
);
  localparam int CMP_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] effN;
  logic [CMP_W-1:0] nextCnt;

  always_comb begin
    effN       = (cycleCount == '0) ? CMP_W'(1) : {1'b0, cycleCount};
    nextCnt    = {1'b0, cnt} + CMP_W'(1);
    lastStrobe = (nextCnt >= effN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.clearCnt) begin
      cnt <= '0;
    end else if (ctl.advance) begin
      cnt <= lastStrobe ? '0 : nextCnt[CNT_W-1:0];
    end
  end

  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearCnt |=> (cnt == '0)); // R10
  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && lastStrobe && !ctl.clearCnt) |=> (cnt == '0)); // R2
endmodule

// File: rtl/comp_seq_control.sv
module comp_seq_control
  import comp_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    convStrobe,
  input  logic    startCmd,
  input  logic    startContinuous,
  input  logic    lastStrobe,
  input  logic    clearDataReady,
  input  logic    irqEnable,
  output seqCtl_t ctl,
  output logic    updatePulse,
  output logic    dataReady,
  output logic    rmsValid,
  output logic    irq
);
  seqState_t state;
  logic      continuous;
  logic      haveOne;
  logic      cycleDone;

  always_comb begin
    ctl.clearCnt = startCmd;
    ctl.advance  = (state == SEQ_RUN) && convStrobe && !startCmd;
    cycleDone    = ctl.advance && lastStrobe;
    irq          = dataReady && irqEnable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= SEQ_IDLE;
      continuous  <= 1'b0;
      haveOne     <= 1'b0;
      rmsValid    <= 1'b0;
      updatePulse <= 1'b0;
    end else begin
      updatePulse <= cycleDone;
      if (startCmd) begin
        state      <= SEQ_RUN;
        continuous <= startContinuous;
        haveOne    <= 1'b0;
        rmsValid   <= 1'b0;
      end else if (cycleDone) begin
        haveOne  <= 1'b1;
        rmsValid <= haveOne;
        if (!continuous) state <= SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReady <= 1'b0;
    end else if (cycleDone) begin
      dataReady <= 1'b1;
    end else if (clearDataReady) begin
      dataReady <= 1'b0;
    end
  end

  AST_UPDATE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |-> $past(state == SEQ_RUN && convStrobe)); // R2
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (updatePulse && !continuous) |-> (state == SEQ_IDLE)); // R5
  AST_RMS_CLEARED_BY_START: assert property (@(posedge clk) disable iff (!rstN)
    startCmd |=> !rmsValid); // R7
endmodule

// File: rtl/comp_cycle_sequencer.sv
module comp_cycle_sequencer
  import comp_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStrobe,
  input  logic             startCmd,
  input  logic             startContinuous,
  input  logic [CNT_W-1:0] cycleCount,
  input  logic             irqEnable,
  input  logic             clearDataReady,
  output logic             updatePulse,
  output logic             dataReady,
  output logic             rmsValid,
  output logic             irq
);
  seqCtl_t ctl;
  logic    lastStrobe;

  comp_seq_control u_control (
    .clk             (clk),
    .rstN            (rstN),
    .convStrobe      (convStrobe),
    .startCmd        (startCmd),
    .startContinuous (startContinuous),
    .lastStrobe      (lastStrobe),
    .clearDataReady  (clearDataReady),
    .irqEnable       (irqEnable),
    .ctl             (ctl),
    .updatePulse     (updatePulse),
    .dataReady       (dataReady),
    .rmsValid        (rmsValid),
    .irq             (irq)
  );

  comp_seq_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cycleCount (cycleCount),
    .lastStrobe (lastStrobe)
  );

  AST_DRDY_ONLY_ON_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> updatePulse); // R3
  AST_IRQ_ON_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (updatePulse && irqEnable) |-> irq); // R4
  AST_UPDATE_SETS_DRDY: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |-> dataReady); // R11
endmodule

// File: tb/comp_cycle_sequencer_test.sv
module comp_cycle_sequencer_test;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convStrobe = 1'b0, startCmd = 1'b0, startContinuous = 1'b0;
  logic irqEnable = 1'b0, clearDataReady = 1'b0;
  logic [CNT_W-1:0] cycleCount = '0;
  logic updatePulse, dataReady, rmsValid, irq;

  int testsRun = 0;
  int testsFailed = 0;
  int updCount = 0;
  bit finished = 0;

  // behavioural reference state
  int  mRun = 0, mCont = 0, mCnt = 0, mCycles = 0;
  bit  mUpd = 0, mDrdy = 0, mRms = 0;

  always #4 clk = ~clk;

  comp_cycle_sequencer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .convStrobe(convStrobe), .startCmd(startCmd),
    .startContinuous(startContinuous), .cycleCount(cycleCount),
    .irqEnable(irqEnable), .clearDataReady(clearDataReady),
    .updatePulse(updatePulse), .dataReady(dataReady),
    .rmsValid(rmsValid), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model advances on each rising edge
  always @(posedge clk) begin
    bit setD;
    int n;
    setD = 0;
    if (!rstN) begin
      mRun = 0; mCont = 0; mCnt = 0; mCycles = 0;
      mUpd = 0; mDrdy = 0; mRms = 0;
    end else begin
      mUpd = 0;
      if (startCmd) begin
        mRun = 1; mCnt = 0; mCont = startContinuous; mCycles = 0; mRms = 0;
      end else if (mRun != 0 && convStrobe) begin
        n = (cycleCount == 0) ? 1 : int'(cycleCount);
        mCnt++;
        if (mCnt >= n) begin
          mCnt = 0; mUpd = 1; setD = 1; mCycles++;
          mRms = (mCycles >= 2);
          if (mCont == 0) mRun = 0;
        end
      end
      if (setD) mDrdy = 1;
      else if (clearDataReady) mDrdy = 0;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(updatePulse === mUpd, "R2 updatePulse", updatePulse, mUpd);
      check(dataReady === mDrdy, "R3 dataReady", dataReady, mDrdy);
      check(irq === (mDrdy && irqEnable), "R4 irq", irq, mDrdy && irqEnable);
      check(rmsValid === mRms, "R7 rmsValid", rmsValid, mRms);
      if (updatePulse === 1'b1) updCount++;
    end
  end

  task automatic cyc(input bit s, input bit st, input bit ct, input bit cl);
    convStrobe = s; startCmd = st; startContinuous = ct; clearDataReady = cl;
    @(posedge clk); #1;
    convStrobe = 0; startCmd = 0; clearDataReady = 0;
  endtask

  task automatic strobes(input int k, input int gap);
    for (int i = 0; i < k; i++) begin
      cyc(1, 0, 0, 0);
      for (int g = 0; g < gap; g++) cyc(0, 0, 0, 0);
    end
  endtask

  task automatic settle();
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    @(negedge clk); #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      testsFailed++; testsRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check({updatePulse, dataReady, rmsValid, irq} === 4'b0, "R1 reset state",
          {updatePulse, dataReady, rmsValid, irq}, 0);
    irqEnable = 1;
    cycleCount = 3;
    #1;
    // R1: strobes while idle
    strobes(7, 1); settle();
    check(updCount == 0, "R1 idle strobes", updCount, 0);

    // R5: single mode, one cycle only, RMS never valid
    base = updCount;
    cyc(0, 1, 0, 0); strobes(9, 0); settle();
    check(updCount - base == 1, "R5 single cycle count", updCount - base, 1);
    check(rmsValid == 0, "R7 single mode rms", rmsValid, 0);
    check(irq == 1, "R4 irq unmasked", irq, 1);
    irqEnable = 0; #1;
    @(negedge clk); #1;
    check(irq == 0, "R4 irq masked", irq, 0);
    cyc(0, 0, 0, 1); settle();
    check(dataReady == 0, "R3 clear", dataReady, 0);

    // R6: continuous, strobe in start cycle not counted
    irqEnable = 1; cycleCount = 4; #1;
    base = updCount;
    cyc(1, 1, 1, 0); strobes(12, 2); settle();
    check(updCount - base == 3, "R6 continuous cycles", updCount - base, 3);
    check(rmsValid == 1, "R7 rms after second", rmsValid, 1);

    // R10: restart one strobe short
    base = updCount;
    cyc(0, 1, 1, 0); strobes(3, 0); cyc(0, 1, 1, 0); settle();
    check(rmsValid == 0, "R10 restart clears rms", rmsValid, 0);
    strobes(3, 0); settle();
    check(updCount - base == 0, "R10 partial discarded", updCount - base, 0);
    strobes(1, 0); settle();
    check(updCount - base == 1, "R10 after full N", updCount - base, 1);

    // R11: clear coincident with update
    cyc(0, 0, 0, 1); cycleCount = 2; #1;
    cyc(0, 1, 0, 0); strobes(1, 0); cyc(1, 0, 0, 1);
    @(negedge clk); #1;
    check(dataReady == 1, "R11 set wins", dataReady, 1);
    cyc(0, 0, 0, 1); @(negedge clk); #1;
    check(irq == 0, "R4 irq drops after clear", irq, 0);

    // R8: N = 1
    cycleCount = 1; #1; base = updCount;
    cyc(0, 1, 1, 0); strobes(5, 1); settle();
    check(updCount - base == 5, "R8 every strobe", updCount - base, 5);

    // R9: N = 0 behaves as 1
    cycleCount = 0; #1; base = updCount;
    cyc(0, 1, 1, 0); strobes(4, 0); settle();
    check(updCount - base == 4, "R9 zero as one", updCount - base, 4);

    // larger N, back-to-back strobes
    cycleCount = 300; #1; base = updCount;
    cyc(0, 1, 1, 0); strobes(600, 0); settle();
    check(updCount - base == 2, "R6 large N", updCount - base, 2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule